// File: doc/BRIEF.md
# Byte-Lane Serial Packet Buffer

This block sits between two one-bit serial lines and four byte-wide memory devices. On the inbound path it collects a 32-bit serial packet, splits it into four bytes and hands one byte to each device on a shared write bus. On the outbound path it takes one byte from each of the four devices in a single cycle and sends the merged 32-bit packet out on the outbound line. One serial packet takes 32 bit cycles, so a device transfer of the same length fits each packet without a stall.

The inbound line has a frame strobe that marks the first bit of each packet. The outbound line raises its own frame strobe on the first bit it sends and an active flag for every bit it sends. The two directions share no state and can run at the same time. A load request that arrives while a packet is still going out is kept. Its packet starts in the cycle right after the current packet ends.

Top module: `snl_lane_buffer`

## Requirements
- R1: While reset is high and after it is released with no stimulus, dev_wr_data is 0, dev_wr_valid is 0, and ser_out, ser_out_frame and ser_out_active are 0.
- R2: Packets travel MSB first and ser_in_frame is high with bit 31. Packet bits 31:24 go to device 0 on dev_wr_data[7:0], bits 23:16 to device 1 on [15:8], bits 15:8 to device 2 on [23:16], and bits 7:0 to device 3 on [31:24].
- R3: All four write lanes update at once, in the cycle after the clock edge that samples bit 0. In that same cycle dev_wr_valid is high for exactly one cycle. At all other times the lanes keep their values.
- R4: When no packet is in progress and ser_in_frame is low, ser_in has no effect on dev_wr_data or dev_wr_valid.
- R5: A frame strobe in the middle of a packet restarts reception at bit 31. The partial packet is dropped and produces no valid pulse.
- R6: Inbound packets may follow one another with no idle cycle between them, and each one is delivered.
- R7: dev_rd_load captures all four read lanes on one clock edge. In the next cycle ser_out_frame is high and ser_out carries packet bit 31. Packet byte k (bits 31-8k down to 24-8k) is device k's byte dev_rd_data[8k+7:8k]. ser_out_active stays high for 32 cycles and ser_out_frame is high only in the first of them.
- R8: A load that arrives while a packet is still going out is held. It starts in the cycle right after that packet's last bit, with no gap. If several loads arrive during one packet, the last one wins.
- R9: When no packet is being sent, ser_out_active and ser_out are 0.
- R10: Both directions work at the same time without disturbing each other.
- R11: A load on the edge that ends the last bit starts the next packet at once, with no gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Inbound serial data, MSB first |
| ser_in_frame | input | 1 | High with the first bit of an inbound packet |
| dev_wr_data | output | 32 | Write bytes, device k on bits 8k+7:8k |
| dev_wr_valid | output | 1 | One-cycle pulse when new write bytes appear |
| dev_rd_data | input | 32 | Read bytes, device k on bits 8k+7:8k |
| dev_rd_load | input | 1 | Capture read bytes and request a send |
| ser_out | output | 1 | Outbound serial data, MSB first |
| ser_out_frame | output | 1 | High with the first outbound bit |
| ser_out_active | output | 1 | High while an outbound bit is valid |

## Verification
Write bytes and dev_wr_valid are due one cycle after the edge that samples bit 0. The frame and bit 31 of an outbound packet are due one cycle after the load edge. A held load's packet starts exactly 32 cycles after the previous frame. The bench changes inputs on the falling edge and reads outputs on the following falling edge, so each read falls in the one cycle where a result is due. It checks every bit cycle of each outbound packet and every middle cycle of each inbound packet, where dev_wr_valid must stay low.

// File: rtl/snl_lane_pkg.sv
package snl_lane_pkg;
  localparam int SNL_LANES  = 4;
  localparam int SNL_LANE_W = 8;

  typedef enum logic {
    TX_IDLE  = 1'b0,
    TX_SHIFT = 1'b1
  } tx_state_e;
endpackage

// File: rtl/snl_lane_swap.sv
module snl_lane_swap #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int PKT_W = LANES * LANE_W
) (
  input  logic [PKT_W-1:0] din,
  output logic [PKT_W-1:0] dout
);
  // packet byte k (counted from the MSB end) <-> device lane k (from the LSB end)
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign dout[i*LANE_W +: LANE_W] = din[(LANES-1-i)*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/snl_lane_bank.sv
module snl_lane_bank #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int PKT_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PKT_W-1:0] din,
  output logic [PKT_W-1:0] q
);
  for (genvar i = 0; i < LANES; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)       q[i*LANE_W +: LANE_W] <= '0;
      else if (load) q[i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
    end
  end

  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/snl_rx_deser.sv
module snl_rx_deser #(
  parameter int PKT_W = 32,
  localparam int CW   = $clog2(PKT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_bit,
  input  logic             ser_frame,
  output logic             done,
  output logic [PKT_W-1:0] word
);
  logic [PKT_W-2:0] sh;
  logic [CW-1:0]    cnt;
  logic             in_pkt;
  logic             last;

  assign last = in_pkt && !ser_frame && (cnt == CW'(PKT_W - 1));
  assign done = last;
  assign word = {sh, ser_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      cnt    <= '0;
      in_pkt <= 1'b0;
    end else if (ser_frame) begin
      sh     <= {sh[PKT_W-3:0], ser_bit};
      cnt    <= CW'(1);
      in_pkt <= 1'b1;
    end else if (in_pkt) begin
      sh     <= {sh[PKT_W-3:0], ser_bit};
      cnt    <= last ? '0 : cnt + 1'b1;
      in_pkt <= !last;
    end
  end

  // R5
  rx_count_chk: assert property (@(posedge clk) disable iff (rst)
    in_pkt |-> (cnt != '0));
  // R6
  rx_done_gap_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/snl_tx_ser.sv
module snl_tx_ser
  import snl_lane_pkg::*;
#(
  parameter int PKT_W = 32,
  localparam int CW   = $clog2(PKT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PKT_W-1:0] direct_pkt,
  input  logic [PKT_W-1:0] held_pkt,
  output logic             ser_bit,
  output logic             ser_frame,
  output logic             ser_active
);
  tx_state_e        state;
  logic [PKT_W-1:0] sh;
  logic [CW-1:0]    cnt;
  logic             pend;
  logic             frame_q;
  logic             last;
  logic             can_start;
  logic             start;

  assign last      = (state == TX_SHIFT) && (cnt == CW'(PKT_W - 1));
  assign can_start = (state == TX_IDLE) || last;
  assign start     = can_start && (pend || load);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TX_IDLE;
      sh      <= '0;
      cnt     <= '0;
      pend    <= 1'b0;
      frame_q <= 1'b0;
    end else if (start) begin
      sh      <= pend ? held_pkt : direct_pkt;
      cnt     <= '0;
      state   <= TX_SHIFT;
      frame_q <= 1'b1;
      pend    <= pend && load;
    end else begin
      frame_q <= 1'b0;
      if (load) pend <= 1'b1;
      if (state == TX_SHIFT) begin
        sh  <= last ? '0 : {sh[PKT_W-2:0], 1'b0};
        cnt <= cnt + 1'b1;
        if (last) state <= TX_IDLE;
      end
    end
  end

  assign ser_bit    = sh[PKT_W-1];
  assign ser_frame  = frame_q;
  assign ser_active = (state == TX_SHIFT);

  // R7
  tx_frame_active_chk: assert property (@(posedge clk) disable iff (rst)
    ser_frame |-> ser_active);
  // R7
  tx_frame_single_chk: assert property (@(posedge clk) disable iff (rst)
    ser_frame |=> (ser_active && !ser_frame));
  // R8
  tx_no_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (last && pend) |=> ser_frame);
  // R9
  tx_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !ser_active |-> !ser_bit);
endmodule

// File: rtl/snl_lane_buffer.sv
module snl_lane_buffer
  import snl_lane_pkg::*;
#(
  parameter int LANES  = SNL_LANES,
  parameter int LANE_W = SNL_LANE_W,
  localparam int PKT_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             ser_in_frame,
  output logic [PKT_W-1:0] dev_wr_data,
  output logic             dev_wr_valid,
  input  logic [PKT_W-1:0] dev_rd_data,
  input  logic             dev_rd_load,
  output logic             ser_out,
  output logic             ser_out_frame,
  output logic             ser_out_active
);
  logic             rx_done;
  logic [PKT_W-1:0] rx_word;
  logic [PKT_W-1:0] rx_lanes;
  logic [PKT_W-1:0] rd_pkt;
  logic [PKT_W-1:0] rd_held;

  // inbound: serial -> lane bank
  snl_rx_deser #(.PKT_W(PKT_W)) u_rx (
    .clk(clk), .rst(rst), .ser_bit(ser_in), .ser_frame(ser_in_frame),
    .done(rx_done), .word(rx_word)
  );

  snl_lane_swap #(.LANES(LANES), .LANE_W(LANE_W)) u_wr_swap (
    .din(rx_word), .dout(rx_lanes)
  );

  snl_lane_bank #(.LANES(LANES), .LANE_W(LANE_W)) u_wr_bank (
    .clk(clk), .rst(rst), .load(rx_done), .din(rx_lanes), .q(dev_wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) dev_wr_valid <= 1'b0;
    else     dev_wr_valid <= rx_done;
  end

  // outbound: lane bank -> serial
  snl_lane_swap #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_swap (
    .din(dev_rd_data), .dout(rd_pkt)
  );

  snl_lane_bank #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_bank (
    .clk(clk), .rst(rst), .load(dev_rd_load), .din(rd_pkt), .q(rd_held)
  );

  snl_tx_ser #(.PKT_W(PKT_W)) u_tx (
    .clk(clk), .rst(rst), .load(dev_rd_load),
    .direct_pkt(rd_pkt), .held_pkt(rd_held),
    .ser_bit(ser_out), .ser_frame(ser_out_frame), .ser_active(ser_out_active)
  );

  // R3
  wr_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dev_wr_valid |=> !dev_wr_valid);
  // R3
  wr_update_chk: assert property (@(posedge clk) disable iff (rst)
    !dev_wr_valid |-> $stable(dev_wr_data));
endmodule

// File: tb/snl_lane_buffer_tb.sv
module snl_lane_buffer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_in = 1'b0;
  logic        ser_in_frame = 1'b0;
  logic [31:0] dev_wr_data;
  logic        dev_wr_valid;
  logic [31:0] dev_rd_data = '0;
  logic        dev_rd_load = 1'b0;
  logic        ser_out;
  logic        ser_out_frame;
  logic        ser_out_active;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  snl_lane_buffer u_dut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .ser_in_frame(ser_in_frame),
    .dev_wr_data(dev_wr_data), .dev_wr_valid(dev_wr_valid),
    .dev_rd_data(dev_rd_data), .dev_rd_load(dev_rd_load),
    .ser_out(ser_out), .ser_out_frame(ser_out_frame),
    .ser_out_active(ser_out_active)
  );

  // packet byte k (from MSB) <-> device k at bits 8k+7:8k
  function automatic logic [31:0] swap_lanes(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rx_send(input logic [31:0] pkt, input int nbits, input string req);
    bit ok = 1;
    for (int i = 0; i < nbits; i++) begin
      ser_in       = pkt[31-i];
      ser_in_frame = (i == 0);
      @(negedge clk);
      if (i < 31 && dev_wr_valid) ok = 0;
    end
    ser_in_frame = 1'b0;
    check(ok, {req, " no early valid"}, {31'd0, !ok}, 32'd0);
    if (nbits == 32) begin
      check(dev_wr_valid === 1'b1, {req, " valid pulse"}, {31'd0, dev_wr_valid}, 32'd1);
      check(dev_wr_data === swap_lanes(pkt), {req, " lanes"}, dev_wr_data, swap_lanes(pkt));
    end
  endtask

  task automatic rx_idle(input int n, input string req);
    logic [31:0] keep = dev_wr_data;
    bit ok = 1;
    for (int i = 0; i < n; i++) begin
      ser_in_frame = 1'b0;
      ser_in       = i[0] ^ i[2];
      @(negedge clk);
      if (dev_wr_valid !== 1'b0 || dev_wr_data !== keep) ok = 0;
    end
    check(ok, req, dev_wr_data, keep);
  endtask

  task automatic tx_expect(input logic [31:0] pkt, input logic [31:0] lb,
                           input logic [31:0] lc, input int kb, input int kc,
                           input string req);
    bit ok = 1;
    logic [31:0] got = '0;
    for (int i = 0; i < 32; i++) begin
      if (ser_out_active !== 1'b1 || ser_out_frame !== (i == 0)) ok = 0;
      got[31-i] = ser_out;
      dev_rd_load = 1'b0;
      if (i == kb) begin dev_rd_data = lb; dev_rd_load = 1'b1; end
      if (i == kc) begin dev_rd_data = lc; dev_rd_load = 1'b1; end
      @(negedge clk);
    end
    dev_rd_load = 1'b0;
    check(ok && got === pkt, req, got, pkt);
  endtask

  task automatic tx_seq(input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c, input int kb, input int kc,
                        input string req);
    dev_rd_data = a;
    dev_rd_load = 1'b1;
    @(negedge clk);
    dev_rd_load = 1'b0;
    dev_rd_data = 32'hFFFF_FFFF;
    tx_expect(swap_lanes(a), b, c, kb, kc, {req, " first packet"});
    if (kb >= 0)
      tx_expect(swap_lanes(kc >= 0 ? c : b), '0, '0, -1, -1, {req, " follow-on packet"});
    check(ser_out_active === 1'b0 && ser_out === 1'b0, "R9 idle after send",
          {30'd0, ser_out_active, ser_out}, 32'd0);
  endtask

  task automatic t_reset();
    check(dev_wr_data === '0 && dev_wr_valid === 1'b0, "R1 write side reset",
          dev_wr_data, 32'd0);
    check(ser_out === 1'b0 && ser_out_frame === 1'b0 && ser_out_active === 1'b0,
          "R1 read side reset", {29'd0, ser_out, ser_out_frame, ser_out_active}, 32'd0);
  endtask

  task automatic t_rx_basic();
    rx_send(32'hA1B2_C3D4, 32, "R2");
    rx_idle(1, "R3 valid drops");
    rx_send(32'h0F1E_2D3C, 32, "R3");
  endtask

  task automatic t_rx_ignore();
    rx_idle(12, "R4 stray bits ignored");
  endtask

  task automatic t_rx_restart();
    rx_send(32'hDEAD_BEEF, 12, "R5 partial");
    rx_send(32'h1357_9BDF, 32, "R5");
    rx_idle(2, "R5 settle");
  endtask

  task automatic t_rx_b2b();
    rx_send(32'h8000_0001, 32, "R6 first");
    rx_send(32'h7FFF_FFFE, 32, "R6 second");
    rx_idle(2, "R6 settle");
  endtask

  task automatic t_tx_basic();
    tx_seq(32'h4433_2211, '0, '0, -1, -1, "R7");
    tx_seq(32'h00FF_8001, '0, '0, -1, -1, "R7 pattern2");
  endtask

  task automatic t_tx_pending();
    tx_seq(32'hCAFE_0123, 32'h5566_7788, '0, 9, -1, "R8");
    tx_seq(32'h1111_2222, 32'h3333_4444, 32'hABCD_EF01, 4, 20, "R8 latest wins");
  endtask

  task automatic t_tx_edge();
    tx_seq(32'h0BAD_F00D, 32'h2468_ACE0, '0, 31, -1, "R11");
  endtask

  task automatic t_concurrent();
    fork
      rx_send(32'h9ABC_DEF0, 32, "R10 inbound");
      tx_seq(32'h1020_3040, '0, '0, -1, -1, "R10 outbound");
    join
    rx_idle(2, "R10 settle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rx_basic();
    t_rx_ignore();
    t_rx_restart();
    t_rx_b2b();
    t_tx_basic();
    t_tx_pending();
    t_tx_edge();
    t_concurrent();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule